// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block walks a register list and turns one block load or block store request into a series of single-word memory transfers. The caller supplies a base address, a 16-bit list of registers, an addressing variant, a load/store select and a writeback enable, and pulses `start`. The sequencer then offers one word transfer per cycle. Each transfer carries a register index, a word address and a write flag. The transfers go out on a valid/ready stream, so the memory side can hold the sequence back for as long as it needs.

All four addressing variants visit the listed registers in ascending index order, so the lowest listed register always lands at the lowest address used. Only the starting address and the direction of the writeback value differ between variants. This fixed ordering lets the block serve as the engine for the four stack models:

- A full stack points at the last valid item; an empty stack points at the next free slot.
- A push and a pop that are built from matching variants place and collect each register at the same address.
- Full-descending, for example, stores with decrement-before and loads with increment-after.

When the last transfer is accepted, the block pulses `done`. If writeback was requested, it presents the updated base value alongside `done`.

Top module: `blkxfer_seq`

## Requirements
- R1: While reset is held and after it is released, `xfer_valid`, `done`, `busy` and `wb_valid` are low.
- R2: The `mode` encoding is 00 increment-after, 01 increment-before, 10 decrement-after and 11 decrement-before. With aligned base B and N listed registers, the first transfer address is B, B+4, B-4N+4 and B-4N respectively.
- R3: Listed registers are transferred in ascending index order. Each accepted transfer moves the address up by 4, so the lowest listed register uses the lowest address.
- R4: `xfer_write` is 1 for a store (`is_load`=0) and 0 for a load (`is_load`=1), for every transfer of the operation.
- R5: A transfer is taken on a rising edge where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low, `xfer_valid` stays high and `xfer_reg`, `xfer_addr` and `xfer_write` hold their values.
- R6: `done` is high for exactly one cycle, the cycle after the edge that takes the last transfer, and `xfer_valid` is low while `done` is high.
- R7: With `wb_en`=1, `wb_valid` is high together with `done`, and `wb_addr` is B+4N for the increment variants or B-4N for the decrement variants. With `wb_en`=0, `wb_valid` stays low.
- R8: An empty register list makes no transfer. `done` rises in the cycle after the start edge, and with writeback `wb_addr` equals B.
- R9: The two low bits of `base_addr` are ignored (B is the base with them cleared), and every transfer address is a multiple of 4.
- R10: A `start` pulse that arrives while `busy` is high is ignored; the running operation continues unchanged.
- R11: For each of the four stack models, a push followed by a pop from the written-back pointer uses the same address for every register, and the pop's writeback restores the original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when not busy |
| base_addr | input | 32 | Base address of the block transfer |
| reg_list | input | 16 | Bit i set means register i is transferred |
| mode | input | 2 | Addressing variant (see R2) |
| is_load | input | 1 | 1 = load, 0 = store |
| wb_en | input | 1 | Request an updated base value |
| xfer_valid | output | 1 | A transfer is offered |
| xfer_ready | input | 1 | Memory accepts the offered transfer |
| xfer_reg | output | 4 | Register index of the offered transfer |
| xfer_addr | output | 32 | Word address of the offered transfer |
| xfer_write | output | 1 | 1 = memory write (store) |
| busy | output | 1 | An operation with transfers is in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | `wb_addr` is meaningful this cycle |
| wb_addr | output | 32 | Updated base value |

## Verification
The first transfer of an operation is offered in the cycle after the `start` edge. Each later transfer appears in the cycle after the edge that took the previous one. `done`, together with `wb_valid` and `wb_addr`, is due one cycle after the edge that takes the last transfer; for an empty list it is due one cycle after the `start` edge. The bench drives inputs and samples every output on the falling edge, and mirrors this timing. It decides `xfer_ready` for each cycle, compares the offered fields against its arithmetic model in every cycle (held beats included), and counts each beat as taken only when it drove ready high for that cycle. It then expects `done` exactly at the next falling edge and checks that `done` has dropped one cycle later.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    WALK_INC_AFTER  = 2'b00,
    WALK_INC_BEFORE = 2'b01,
    WALK_DEC_AFTER  = 2'b10,
    WALK_DEC_BEFORE = 2'b11
  } walk_mode_t;
endpackage

// File: rtl/blkxfer_plan.sv
// Computes the start and writeback addresses of one block transfer.
module blkxfer_plan
  import blkxfer_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0]   base_al,
  input  logic [NREG-1:0] reg_list,
  input  walk_mode_t      mode,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   final_addr
);
  localparam int CNTW = $clog2(NREG + 1);
  localparam int ALB  = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [CNTW-1:0] count;
  logic [AW-1:0]   span;

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CNTW'(reg_list[i]);
    end
  end

  assign span = AW'(count) << ALB;

  always_comb begin
    unique case (mode)
      WALK_INC_AFTER:  first_addr = base_al;
      WALK_INC_BEFORE: first_addr = base_al + STEP;
      WALK_DEC_AFTER:  first_addr = base_al - span + STEP;
      default:         first_addr = base_al - span;
    endcase
    final_addr = mode[1] ? (base_al - span) : (base_al + span);
  end
endmodule

// File: rtl/blkxfer_pick.sv
// Finds the lowest pending register and the list that remains after it.
module blkxfer_pick #(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0]         pending,
  output logic [$clog2(NREG)-1:0] idx,
  output logic [NREG-1:0]         pending_next
);
  localparam int IDXW = $clog2(NREG);

  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDXW'(i);
    end
  end

  assign pending_next = pending & (pending - NREG'(1));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [AW-1:0]           base_addr,
  input  logic [NREG-1:0]         reg_list,
  input  logic [1:0]              mode,
  input  logic                    is_load,
  input  logic                    wb_en,
  output logic                    xfer_valid,
  input  logic                    xfer_ready,
  output logic [$clog2(NREG)-1:0] xfer_reg,
  output logic [AW-1:0]           xfer_addr,
  output logic                    xfer_write,
  output logic                    busy,
  output logic                    done,
  output logic                    wb_valid,
  output logic [AW-1:0]           wb_addr
);
  localparam int IDXW = $clog2(NREG);
  localparam int ALB  = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] STEP     = AW'(WORD_BYTES);
  localparam logic [AW-1:0] LOW_MASK = AW'(WORD_BYTES - 1);

  logic [AW-1:0]   base_al;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_addr;
  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_next;
  logic [IDXW-1:0] pick_idx;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   wb_q;
  logic            busy_q;
  logic            done_q;
  logic            wr_q;
  logic            wben_q;
  logic            take;
  logic            accept;

  assign base_al = base_addr & ~LOW_MASK;

  blkxfer_plan #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base_al    (base_al),
    .reg_list   (reg_list),
    .mode       (walk_mode_t'(mode)),
    .first_addr (first_addr),
    .final_addr (final_addr)
  );

  blkxfer_pick #(.NREG(NREG)) u_pick (
    .pending      (pend_q),
    .idx          (pick_idx),
    .pending_next (pend_next)
  );

  assign accept = start && !busy_q;
  assign take   = busy_q && xfer_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      addr_q <= '0;
      wb_q   <= '0;
      wr_q   <= 1'b0;
      wben_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q <= reg_list;
        addr_q <= first_addr;
        wb_q   <= final_addr;
        wr_q   <= !is_load;
        wben_q <= wb_en;
        if (reg_list == '0) done_q <= 1'b1;
        else                busy_q <= 1'b1;
      end else if (take) begin
        pend_q <= pend_next;
        addr_q <= addr_q + STEP;
        if (pend_next == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign xfer_valid = busy_q;
  assign xfer_reg   = pick_idx;
  assign xfer_addr  = addr_q;
  assign xfer_write = wr_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign wb_valid   = done_q && wben_q;
  assign wb_addr    = wb_q;

  // R3: address climbs one word per accepted transfer
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_addr == $past(xfer_addr) + STEP));

  // R3: register indices strictly ascend within an operation
  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_reg > $past(xfer_reg)));

  // R5: a stalled transfer keeps its fields
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr)
                                     && $stable(xfer_reg) && $stable(xfer_write)));

  // R6: completion never overlaps an offered transfer
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_valid);

  // R7: writeback is only reported with completion
  assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  // R8: empty list completes in the next cycle without transfers
  assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && reg_list == '0) |=> (done && !xfer_valid));

  // R9: offered addresses are word aligned
  assert_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_addr[ALB-1:0] == '0));
endmodule

// File: tb/sim_blkxfer_seq.sv
module sim_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_list = '0;
  logic [1:0]  mode = '0;
  logic        is_load = 1'b0;
  logic        wb_en = 1'b0;
  logic        xfer_ready = 1'b0;
  logic        xfer_valid;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr;
  logic        xfer_write;
  logic        busy;
  logic        done;
  logic        wb_valid;
  logic [31:0] wb_addr;

  int checks = 0;
  int fails = 0;
  logic [31:0] seen [16];
  logic [31:0] pushed [16];
  logic [31:0] last_wb;

  always #2 clk = ~clk;

  blkxfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .mode(mode), .is_load(is_load), .wb_en(wb_en),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_reg(xfer_reg),
    .xfer_addr(xfer_addr), .xfer_write(xfer_write), .busy(busy), .done(done),
    .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic int lowest(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                        input logic [1:0] md, input bit ld, input bit wb,
                        input int stall);
    logic [31:0] bal, first, fin;
    logic [15:0] rm;
    int n, k, cyc;
    bit rdy;
    bal = base & 32'hFFFF_FFFC;
    n = popc(mask);
    case (md)
      2'd0:    first = bal;
      2'd1:    first = bal + 32'd4;
      2'd2:    first = bal - 32'(4 * n) + 32'd4;
      default: first = bal - 32'(4 * n);
    endcase
    fin = md[1] ? bal - 32'(4 * n) : bal + 32'(4 * n);
    @(negedge clk);
    base_addr = base; reg_list = mask; mode = md; is_load = ld; wb_en = wb;
    start = 1'b1; xfer_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    rm = mask; k = 0; cyc = 0;
    while (k < n && cyc < 200) begin
      start = 1'b0;
      rdy = (stall == 0) || (((cyc * 5 + stall) % 3) != 0);
      xfer_ready = rdy;
      chk(xfer_valid === 1'b1, "R5 valid offered", 32'(xfer_valid), 32'd1);
      if (k == 0) chk(xfer_addr === first, "R2 first address", xfer_addr, first);
      chk(xfer_addr === first + 32'(4 * k), "R3 address step", xfer_addr, first + 32'(4 * k));
      chk(xfer_reg === 4'(lowest(rm)), "R3 register order", 32'(xfer_reg), 32'(lowest(rm)));
      chk(xfer_write === !ld, "R4 write flag", 32'(xfer_write), 32'(!ld));
      chk(xfer_addr[1:0] === 2'b00, "R9 alignment", xfer_addr, {xfer_addr[31:2], 2'b00});
      if (cyc == 1) begin
        // R10: strobe while busy with a different request
        start = 1'b1; base_addr = 32'hDEAD_0000; reg_list = 16'h0; mode = ~md;
      end
      if (rdy) begin
        seen[lowest(rm)] = xfer_addr;
        rm = rm & (rm - 16'd1);
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; xfer_ready = 1'b0;
    chk(cyc < 200, "R5 progress", 32'(cyc), 32'd200);
    chk(done === 1'b1, (n == 0) ? "R8 empty done" : "R6 done timing", 32'(done), 32'd1);
    chk(xfer_valid === 1'b0, "R6 no offer with done", 32'(xfer_valid), 32'd0);
    chk(wb_valid === wb, "R7 writeback flag", 32'(wb_valid), 32'(wb));
    if (wb) chk(wb_addr === fin, (n == 0) ? "R8 base unchanged" : "R7 writeback value",
                wb_addr, fin);
    last_wb = fin;
    @(negedge clk);
    chk(done === 1'b0, "R6 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic [1:0] push_md, pop_md;
    logic [31:0] b;
    repeat (3) @(negedge clk);
    chk(xfer_valid === 1'b0 && done === 1'b0 && busy === 1'b0 && wb_valid === 1'b0,
        "R1 reset state", {xfer_valid, done, busy, wb_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xfer_valid === 1'b0 && done === 1'b0 && busy === 1'b0,
        "R1 idle after reset", {xfer_valid, done, busy}, 32'd0);

    lf = 16'hACE1;
    for (int md = 0; md < 4; md++) begin
      for (int ld = 0; ld < 2; ld++) begin
        for (int t = 0; t < 58; t++) begin
          logic [15:0] m;
          if (t < 16) m = 16'd1 << t;
          else if (t == 16) m = 16'h0000;
          else if (t == 17) m = 16'hFFFF;
          else begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            m = lf;
          end
          b = 32'h0000_4000 + 32'(t * 36) + 32'(t % 4);
          run_op(b, m, 2'(md), ld[0], t[0], t % 3);
        end
      end
    end

    // R11: stack models push then pop
    for (int sm = 0; sm < 4; sm++) begin
      logic [15:0] m;
      case (sm)
        0: begin push_md = 2'd3; pop_md = 2'd0; end
        1: begin push_md = 2'd1; pop_md = 2'd2; end
        2: begin push_md = 2'd2; pop_md = 2'd1; end
        default: begin push_md = 2'd0; pop_md = 2'd3; end
      endcase
      m = 16'hA5C3 ^ 16'(sm * 16'h1111);
      b = 32'h0000_8000 + 32'(sm * 256);
      run_op(b, m, push_md, 1'b0, 1'b1, 1);
      for (int r = 0; r < 16; r++) pushed[r] = seen[r];
      run_op(last_wb, m, pop_md, 1'b1, 1'b1, 2);
      for (int r = 0; r < 16; r++)
        if (m[r]) chk(seen[r] === pushed[r], "R11 same slot", seen[r], pushed[r]);
      chk(last_wb === b, "R11 pointer restored", last_wb, b);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule